// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control heart of a microprogrammed processor. A start strobe presents a machine opcode, and the sequencer then walks a routine of 21-bit micro-instructions held in an internal read-only control store. Each micro-instruction it executes is split into control fields and presented on registered outputs, one per clock, for a datapath to act on. When the routine reaches its end marker, the block raises done for one cycle and falls idle, ready for the next opcode.

Every opcode owns a window of sixteen consecutive control-store slots, and a 4-bit step counter moves through that window without any explicit next-address field. A routine that fits in sixteen steps therefore costs no jump at all. A conditional micro-jump, tested against an external condition input, can move the routine to any window. The store is organised as wide rows that each carry four micro-instructions. The upper step bits join the opcode to form the row address, and the lower step bits pick the quarter of the fetched row.

Top module: `msq_top`

## Requirements
- R1: A micro-instruction word is laid out, from bit 20 down to bit 0, as source select (5 bits, 20:16), destination select (5 bits, 15:11), type (2 bits, 10:9), operation (5 bits, 8:4), modifier (3 bits, 3:1) and flag-update enable (bit 0). A valid output beat carries its source, destination and type unchanged.
- R2: The control store holds 512 words as 128 rows of 84 bits. The row address is {opcode, step[3:2]}, and step[1:0] selects the word within the row, with lane 0 in bits 20:0. Routines run across row boundaries without a gap.
- R3: A start strobe seen while idle sets the window to the opcode and the step to 0, and raises busy on that edge. The beat for the micro-instruction at the k-th step of execution (k = 0, 1, ...) appears k+1 rising edges after the start edge.
- R4: Except when a jump is taken, the step counter advances by one each cycle and wraps from 15 to 0 within the same window.
- R5: Type 0 is a conditional jump. When cond_i is high in its execute cycle, the window is loaded from the operation field and the step from the modifier field (zero-extended). When cond_i is low, the step increments. The jump itself is emitted as a beat with type 0 and the operation, modifier, aux and flag outputs at zero.
- R6: Type 1 is an ALU operation. Its beat drives alu_o with the operation field, mod_o with the modifier field and flag_o with the flag bit. For every other type, alu_o, mod_o and flag_o are 0.
- R7: Types 2 and 3 use the long layout. aux_o carries {operation, modifier} as one 8-bit field. For types 0 and 1, aux_o is 0.
- R8: The word with type 3, operation 31 and modifier 7 ends the routine. It produces no beat. done_o is high for exactly one cycle, busy_o falls on the same edge, and the block is idle again. Unprogrammed slots hold this word.
- R9: A start strobe while busy is ignored, and the running routine continues unchanged.
- R10: A synchronous reset puts the block in idle with busy, done, valid and all field outputs at 0, abandoning any routine in progress.
- R11: cond_i has no effect on any micro-instruction other than a type 0 jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the routine for opcode_i (idle only) |
| opcode_i | input | 5 | Machine opcode; selects the 16-slot window |
| cond_i | input | 1 | Condition tested by jump micro-instructions |
| busy_o | output | 1 | A routine is running |
| done_o | output | 1 | One-cycle pulse at routine end |
| valid_o | output | 1 | Field outputs hold an executed micro-instruction |
| src_o | output | 5 | Source select |
| dst_o | output | 5 | Destination select |
| typ_o | output | 2 | Micro-instruction type |
| alu_o | output | 5 | ALU operation (type 1 only) |
| mod_o | output | 3 | Modifier (type 1 only) |
| aux_o | output | 8 | Long-layout field (types 2 and 3) |
| flag_o | output | 1 | Flag-update enable (type 1 only) |

## Verification
The bench builds the block with its default parameters: a 5-bit opcode, a 4-bit step counter and four words per row. This makes the whole 512-word store and its built-in test program reachable. With these sizes, a six-step routine crosses a row boundary, and a sixteen-step loop exercises the counter wrap inside one window. Jumps can be steered both ways by holding the condition input before the jump executes. A start strobe injected mid-routine, and a reset injected mid-routine, land at known step positions.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int SRC_W = 5;
  localparam int DST_W = 5;
  localparam int TYP_W = 2;
  localparam int OP_W  = 5;
  localparam int MOD_W = 3;
  localparam int AUX_W = OP_W + MOD_W;
  localparam int UI_W  = SRC_W + DST_W + TYP_W + OP_W + MOD_W + 1;

  localparam logic [TYP_W-1:0] T_JMP  = 2'd0;
  localparam logic [TYP_W-1:0] T_ALU  = 2'd1;
  localparam logic [TYP_W-1:0] T_LNG2 = 2'd2;
  localparam logic [TYP_W-1:0] T_LNG3 = 2'd3;
  localparam logic [OP_W-1:0]  END_OP  = '1;
  localparam logic [MOD_W-1:0] END_MOD = '1;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DST_W-1:0] dst;
    logic [TYP_W-1:0] typ;
    logic [OP_W-1:0]  op;
    logic [MOD_W-1:0] mod;
    logic             flag;
  } uinst_t;

  function automatic uinst_t mk_end();
    uinst_t u;
    u = '0;
    u.typ = T_LNG3;
    u.op  = END_OP;
    u.mod = END_MOD;
    return u;
  endfunction

  function automatic uinst_t mk_alu(int s, int d, int a, int m, int f);
    uinst_t u;
    u.src  = SRC_W'(s);
    u.dst  = DST_W'(d);
    u.typ  = T_ALU;
    u.op   = OP_W'(a);
    u.mod  = MOD_W'(m);
    u.flag = f[0];
    return u;
  endfunction

  function automatic uinst_t mk_jmp(int win, int stp);
    uinst_t u;
    u = '0;
    u.typ = T_JMP;
    u.op  = OP_W'(win);
    u.mod = MOD_W'(stp);
    return u;
  endfunction

  function automatic uinst_t mk_long(logic [TYP_W-1:0] t, int s, int d, logic [AUX_W-1:0] aux);
    uinst_t u;
    u.src  = SRC_W'(s);
    u.dst  = DST_W'(d);
    u.typ  = t;
    u.op   = aux[AUX_W-1:MOD_W];
    u.mod  = aux[MOD_W-1:0];
    u.flag = 1'b0;
    return u;
  endfunction

  // Test program: word at step stp of window win; empty slots end the routine.
  function automatic uinst_t ucode(int win, int stp);
    uinst_t u;
    u = mk_end();
    case (win)
      1: begin
        if (stp == 0) u = mk_alu(1, 2, 3, 1, 1);
        if (stp == 1) u = mk_alu(4, 5, 6, 0, 0);
        if (stp == 2) u = mk_long(T_LNG3, 7, 8, 8'hA5);
      end
      2: if (stp < 6) u = mk_alu(stp, stp + 8, stp + 1, stp % 8, stp % 2);
      3: begin
        if (stp == 0) u = mk_jmp(4, 2);
        if (stp == 1) u = mk_alu(9, 10, 11, 2, 1);
      end
      4: if (stp == 2) u = mk_alu(17, 18, 19, 3, 0);
      6: u = (stp == 0) ? mk_jmp(7, 0) : mk_alu(stp, stp, stp, 0, 1);
      default: ;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/msq_rom.sv
module msq_rom
  import msq_pkg::*;
#(
  parameter int OPC_W    = 5,
  parameter int STEP_W   = 4,
  parameter int LANE_LOG = 2
) (
  input  logic                                clk,
  input  logic [OPC_W+STEP_W-LANE_LOG-1:0]    row_addr,
  output logic [(2**LANE_LOG)*UI_W-1:0]       row_q
);
  localparam int LANES = 2 ** LANE_LOG;
  localparam int ROWS  = 2 ** (OPC_W + STEP_W - LANE_LOG);
  localparam int ROW_W = LANES * UI_W;
  localparam int WIN_N = 2 ** STEP_W;

  logic [ROW_W-1:0] rom_mem [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      for (int l = 0; l < LANES; l++) begin
        rom_mem[r][l*UI_W +: UI_W] = ucode((r * LANES + l) / WIN_N, (r * LANES + l) % WIN_N);
      end
    end
  end

  always_ff @(posedge clk) begin
    row_q <= rom_mem[row_addr];
  end
endmodule

// File: rtl/msq_seq.sv
module msq_seq
  import msq_pkg::*;
#(
  parameter int OPC_W    = 5,
  parameter int STEP_W   = 4,
  parameter int LANE_LOG = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start_i,
  input  logic [OPC_W-1:0]                 opcode_i,
  input  logic                             cond_i,
  input  logic [TYP_W-1:0]                 cur_typ,
  input  logic [OP_W-1:0]                  cur_op,
  input  logic [MOD_W-1:0]                 cur_mod,
  output logic [OPC_W+STEP_W-LANE_LOG-1:0] row_addr,
  output logic [LANE_LOG-1:0]              lane,
  output logic                             issue,
  output logic                             busy_o,
  output logic                             done_o
);
  logic [OPC_W-1:0]  win_q, win_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic              is_end, take_jmp;

  assign is_end   = busy_o && (cur_typ == T_LNG3) && (cur_op == END_OP) && (cur_mod == END_MOD);
  assign take_jmp = busy_o && (cur_typ == T_JMP) && cond_i;
  assign issue    = busy_o && !is_end;

  always_comb begin
    win_n  = win_q;
    step_n = step_q;
    if (!busy_o) begin
      if (start_i) begin
        win_n  = opcode_i;
        step_n = '0;
      end
    end else if (take_jmp) begin
      win_n  = cur_op[OPC_W-1:0];
      step_n = STEP_W'(cur_mod);
    end else if (!is_end) begin
      step_n = step_q + STEP_W'(1);
    end
  end

  assign row_addr = {win_n, step_n[STEP_W-1:LANE_LOG]};
  assign lane     = step_q[LANE_LOG-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      step_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      win_q  <= win_n;
      step_q <= step_n;
      done_o <= is_end;
      if (!busy_o && start_i) busy_o <= 1'b1;
      else if (is_end)        busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/msq_dec.sv
module msq_dec
  import msq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  uinst_t           cur,
  output logic             valid_o,
  output logic [SRC_W-1:0] src_o,
  output logic [DST_W-1:0] dst_o,
  output logic [TYP_W-1:0] typ_o,
  output logic [OP_W-1:0]  alu_o,
  output logic [MOD_W-1:0] mod_o,
  output logic [AUX_W-1:0] aux_o,
  output logic             flag_o
);
  logic is_alu, is_long;
  assign is_alu  = (cur.typ == T_ALU);
  assign is_long = cur.typ[TYP_W-1];

  always_ff @(posedge clk) begin
    if (rst || !issue) begin
      valid_o <= 1'b0;
      src_o   <= '0;
      dst_o   <= '0;
      typ_o   <= '0;
      alu_o   <= '0;
      mod_o   <= '0;
      aux_o   <= '0;
      flag_o  <= 1'b0;
    end else begin
      valid_o <= 1'b1;
      src_o   <= cur.src;
      dst_o   <= cur.dst;
      typ_o   <= cur.typ;
      alu_o   <= is_alu  ? cur.op   : '0;
      mod_o   <= is_alu  ? cur.mod  : '0;
      flag_o  <= is_alu  ? cur.flag : 1'b0;
      aux_o   <= is_long ? {cur.op, cur.mod} : '0;
    end
  end
endmodule

// File: rtl/msq_top.sv
module msq_top
  import msq_pkg::*;
#(
  parameter int OPC_W    = 5,
  parameter int STEP_W   = 4,
  parameter int LANE_LOG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             cond_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic [SRC_W-1:0] src_o,
  output logic [DST_W-1:0] dst_o,
  output logic [TYP_W-1:0] typ_o,
  output logic [OP_W-1:0]  alu_o,
  output logic [MOD_W-1:0] mod_o,
  output logic [AUX_W-1:0] aux_o,
  output logic             flag_o
);
  localparam int ROW_AW = OPC_W + STEP_W - LANE_LOG;
  localparam int ROW_W  = (2 ** LANE_LOG) * UI_W;

  logic [ROW_AW-1:0]   row_addr;
  logic [ROW_W-1:0]    row_q;
  logic [LANE_LOG-1:0] lane;
  logic                issue;
  uinst_t              cur;

  assign cur = row_q[lane*UI_W +: UI_W];

  msq_rom #(.OPC_W(OPC_W), .STEP_W(STEP_W), .LANE_LOG(LANE_LOG)) u_rom (
    .clk(clk), .row_addr(row_addr), .row_q(row_q)
  );

  msq_seq #(.OPC_W(OPC_W), .STEP_W(STEP_W), .LANE_LOG(LANE_LOG)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i), .cond_i(cond_i),
    .cur_typ(cur.typ), .cur_op(cur.op), .cur_mod(cur.mod),
    .row_addr(row_addr), .lane(lane), .issue(issue), .busy_o(busy_o), .done_o(done_o)
  );

  msq_dec u_dec (
    .clk(clk), .rst(rst), .issue(issue), .cur(cur),
    .valid_o(valid_o), .src_o(src_o), .dst_o(dst_o), .typ_o(typ_o),
    .alu_o(alu_o), .mod_o(mod_o), .aux_o(aux_o), .flag_o(flag_o)
  );
endmodule

// File: rtl/msq_chk.sv
module msq_chk
  import msq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             valid_o,
  input logic [SRC_W-1:0] src_o,
  input logic [DST_W-1:0] dst_o,
  input logic [TYP_W-1:0] typ_o,
  input logic [OP_W-1:0]  alu_o,
  input logic [MOD_W-1:0] mod_o,
  input logic [AUX_W-1:0] aux_o,
  input logic             flag_o
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) (!busy_o && start_i) |=> busy_o); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done_o |-> (!busy_o && !valid_o)); // R8
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst) valid_o |-> busy_o); // R3
  AST_NONALU_ZERO: assert property (@(posedge clk) disable iff (rst)
    (typ_o != 2'd1) |-> (alu_o == '0 && mod_o == '0 && !flag_o)); // R6
  AST_SHORT_NOAUX: assert property (@(posedge clk) disable iff (rst) !typ_o[1] |-> (aux_o == '0)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!valid_o && src_o == '0 && dst_o == '0 && typ_o == '0)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!busy_o && !done_o && !valid_o)); // R10
endmodule

bind msq_top msq_chk u_chk (.*);

// File: tb/sim_msq_top.sv
`timescale 1ns/1ps
module sim_msq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [4:0] opcode_i = '0;
  logic       cond_i = 1'b0;
  logic       busy_o, done_o, valid_o, flag_o;
  logic [4:0] src_o, dst_o, alu_o;
  logic [1:0] typ_o;
  logic [2:0] mod_o;
  logic [7:0] aux_o;

  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  msq_top u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i), .cond_i(cond_i),
    .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o), .src_o(src_o), .dst_o(dst_o),
    .typ_o(typ_o), .alu_o(alu_o), .mod_o(mod_o), .aux_o(aux_o), .flag_o(flag_o)
  );

  typedef struct packed {
    logic [4:0] op;
    logic       c;
    logic [5:0] n;
    logic [3:0] poke;
    logic [4:0] raise;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{5'd0, 1'b0, 6'd0,  4'd0, 5'd0},
    '{5'd1, 1'b0, 6'd3,  4'd0, 5'd0},
    '{5'd1, 1'b1, 6'd3,  4'd0, 5'd0},
    '{5'd2, 1'b0, 6'd6,  4'd0, 5'd0},
    '{5'd3, 1'b0, 6'd2,  4'd0, 5'd0},
    '{5'd3, 1'b1, 6'd2,  4'd0, 5'd0},
    '{5'd9, 1'b1, 6'd0,  4'd0, 5'd0},
    '{5'd2, 1'b1, 6'd6,  4'd2, 5'd0},
    '{5'd6, 1'b0, 6'd17, 4'd0, 5'd16}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 6:    return "R8";
      1:       return "R3";
      2:       return "R11";
      3:       return "R2";
      4, 5:    return "R5";
      7:       return "R9";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [28:0] pk(int s, int d, int t, int a, int m, int x, int f);
    return {5'(s), 5'(d), 2'(t), 5'(a), 3'(m), 8'(x), 1'(f)};
  endfunction

  // Expected beats from the test program and the field rules R1, R5, R6, R7
  function automatic logic [28:0] exp_beat(int op, bit c, int k);
    case (op)
      1: begin
        if (k == 0) return pk(1, 2, 1, 3, 1, 0, 1);
        if (k == 1) return pk(4, 5, 1, 6, 0, 0, 0);
        return pk(7, 8, 3, 0, 0, 8'hA5, 0);
      end
      2: return pk(k, k + 8, 1, k + 1, k % 8, 0, k % 2);
      3: begin
        if (k == 0) return pk(0, 0, 0, 0, 0, 0, 0);
        if (c) return pk(17, 18, 1, 19, 3, 0, 0);
        return pk(9, 10, 1, 11, 2, 0, 1);
      end
      6: begin
        if (k == 0 || k == 16) return pk(0, 0, 0, 0, 0, 0, 0);
        return pk(k, k, 1, k, 0, 0, 1);
      end
      default: return '1;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(vec_t v, string tag);
    int k = 0;
    int cyc = 0;
    bit fin = 1'b0;
    logic [28:0] act, exp;
    @(negedge clk);
    start_i = 1'b1; opcode_i = v.op; cond_i = v.c;
    @(negedge clk);
    start_i = 1'b0;
    while (!fin && cyc < 40) begin
      @(negedge clk);
      cyc++;
      start_i = (v.poke != 0 && cyc == int'(v.poke));
      if (start_i) opcode_i = 5'd0;
      if (valid_o) begin
        act = {src_o, dst_o, typ_o, alu_o, mod_o, aux_o, flag_o};
        exp = exp_beat(v.op, v.c, k);
        if (typ_o == 2'd0)      check(act == exp, tag, "R5 jump beat",  int'(act), int'(exp));
        else if (typ_o == 2'd1) check(act == exp, tag, "R1/R6 alu beat", int'(act), int'(exp));
        else                    check(act == exp, tag, "R7 long beat",  int'(act), int'(exp));
        if (k == 0) check(cyc == 1, "R3", "first beat cycle", cyc, 1);
        k++;
        if (v.raise != 0 && k == int'(v.raise)) cond_i = 1'b1;
      end
      if (done_o) begin
        fin = 1'b1;
        check(k == int'(v.n), tag, "beat count", k, int'(v.n));
        check(cyc == int'(v.n) + 1, "R8", "done cycle", cyc, int'(v.n) + 1);
        check(!busy_o && !valid_o, "R8", "busy/valid at done", {busy_o, valid_o}, 0);
      end else if (!busy_o) begin
        check(1'b0, tag, "busy dropped early", 0, 1);
      end
    end
    start_i = 1'b0;
    if (!fin) check(1'b0, "R8", "no done pulse", 0, 1);
    @(negedge clk);
    check(!done_o && !busy_o, "R8", "done one cycle, idle", {done_o, busy_o}, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!ended) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check({busy_o, done_o, valid_o} == 3'b000, "R10", "reset handshake", {busy_o, done_o, valid_o}, 0);
    check({src_o, dst_o, typ_o, alu_o, mod_o, aux_o, flag_o} == '0, "R10", "reset fields",
          int'({src_o, dst_o, typ_o, alu_o, mod_o, aux_o, flag_o}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy_o && !valid_o, "R10", "idle without start", {busy_o, valid_o}, 0);

    for (int i = 0; i < NVEC; i++) begin
      cond_i = 1'b0;
      run(VEC[i], vec_tag(i));
    end

    // R10: reset in the middle of a routine
    cond_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; opcode_i = 5'd2;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o && valid_o, "R10", "routine running before reset", {busy_o, valid_o}, 3);
    rst = 1'b1;
    @(negedge clk);
    check({busy_o, done_o, valid_o} == 3'b000, "R10", "mid-run reset handshake", {busy_o, done_o, valid_o}, 0);
    check({src_o, dst_o, typ_o, alu_o} == '0, "R10", "mid-run reset fields", int'({src_o, dst_o, typ_o, alu_o}), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && !valid_o, "R10", "stays idle after reset", {busy_o, done_o, valid_o}, 0);
    run(VEC[1], "R10");

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule